// File: doc/BRIEF.md
# Floating-Point Rounding and Exception Stage

This stage sits at the end of a single-precision adder datapath. It receives a significand that an earlier stage has already aligned, added and normalized. With it come a guard bit, a sticky bit, a tentative biased exponent, the result sign and class flags for the operands.

The stage does the following:
- picks a rounding direction from a 2-bit mode field and applies the increment;
- corrects the exponent when the increment carries out of the significand;
- assembles the 32-bit result word;
- raises overflow, underflow, inexact and invalid.

Overflow and underflow can be trapped. A trapped result is returned with its exponent moved by a fixed bias of 192, so that a handler can recover the true value.

The tentative exponent is 9 bits wide, so that values above the format maximum can be passed in. An exponent of zero marks a subnormal significand, whose hidden bit is 0. The result can optionally be registered, and it is registered by default.

Control word layout:
- bits [1:0]: rounding mode;
- bit 2: overflow trap enable;
- bit 3: underflow trap enable;
- bit 4: operation select, which this addition-only stage does not use.

Top module: `fp_round_exc`

## Requirements
- R1: Mode 00 rounds to nearest, ties to even. The significand is incremented when guard is 1 and either sticky or the significand LSB is 1.
- R2: Mode 01 truncates. Mode 10 increments when guard or sticky is set and the sign is 0. Mode 11 increments when guard or sticky is set and the sign is 1.
- R3: An increment that carries out of the 24-bit significand gives fraction 0 and an exponent one higher than exp_i.
- R4: A subnormal input (exp_i = 0) whose rounding sets the hidden bit gives exponent field 1.
- R5: A rounded exponent of 255 or more raises ovf_o. When untrapped, inexact_o is 1. The result is infinity in mode 00, in mode 10 with sign 0 and in mode 11 with sign 1. In every other case it is the largest finite magnitude, 0x7F7FFFFF with the sign bit applied.
- R6: With ctrl_i[2] set, an overflowing result keeps the rounded fraction. Its exponent field is (rounded exponent − 192) mod 256, and inexact_o equals guard OR sticky.
- R7: With exp_i = 0, unf_o is raised when guard or sticky is set. With ctrl_i[3] set, unf_o is raised whenever exp_i = 0, and the exponent field becomes (exponent + 192) mod 256.
- R8: invalid_o is raised when nan_i or inf_i is set, and ovf_o, unf_o and inexact_o are then 0. When nan_i or inf_clash_i is set, the result is 0x7FC00000. Otherwise it is infinity carrying sign_i.
- R9: For ordinary finite results, inexact_o equals guard_i OR sticky_i.
- R10: ctrl_i[4] has no effect on any output.
- R11: Outputs appear one clock after their inputs. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 24 | Normalized significand with hidden bit at MSB |
| guard_i | input | 1 | First bit below the significand |
| sticky_i | input | 1 | OR of all lower discarded bits |
| exp_i | input | 9 | Tentative biased exponent, 0 means subnormal |
| sign_i | input | 1 | Result sign |
| nan_i | input | 1 | An operand is NaN |
| inf_i | input | 1 | An operand is infinity |
| inf_clash_i | input | 1 | Infinities of opposite sign were added |
| ctrl_i | input | 5 | Mode [1:0], overflow trap [2], underflow trap [3], operation [4] |
| result_o | output | 32 | Packed single-precision result |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inexact_o | output | 1 | Inexact flag |
| invalid_o | output | 1 | Invalid flag |

## Verification
Clocked properties on the registered outputs hold on every cycle:
- the invalid flag excludes the other three flags;
- an untrapped overflow is always inexact;
- truncation mode never overflows to infinity;
- a trapped overflow reports inexact exactly from guard and sticky;
- underflow only ever follows a zero input exponent.

The exact rounded bit patterns can only be shown by the bench scenarios. These include the tie-to-even decisions, the carry-out exponent step, subnormal promotion, the re-biased trap exponents and the invariance to the operation bit.

// File: rtl/fp_rnd_pkg.sv
`timescale 1ns/1ps
package fp_rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rnd_mode_e;

  localparam int CTRL_W      = 5;
  localparam int CB_OVF_TRAP = 2;
  localparam int CB_UNF_TRAP = 3;
endpackage

// File: rtl/fp_round_inc.sv
`timescale 1ns/1ps
module fp_round_inc
  import fp_rnd_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  rnd_mode_e        mode_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o,
  output logic             inexact_o
);
  logic             up;
  logic [SIG_W:0]   sum;

  assign inexact_o = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN: up = guard_i & (sticky_i | sig_i[0]);
      RM_TO_ZERO:   up = 1'b0;
      RM_UP:        up = inexact_o & ~sign_i;
      RM_DOWN:      up = inexact_o & sign_i;
      default:      up = 1'b0;
    endcase
  end

  assign sum     = {1'b0, sig_i} + {{SIG_W{1'b0}}, up};
  assign carry_o = sum[SIG_W];
  // carry out means the sum is exactly 2.0: shift right one place
  assign sig_o   = carry_o ? sum[SIG_W:1] : sum[SIG_W-1:0];
endmodule

// File: rtl/fp_exp_adj.sv
`timescale 1ns/1ps
module fp_exp_adj #(
  parameter int EXP_W = 8,
  localparam int XW   = EXP_W + 2
) (
  input  logic [EXP_W:0]  exp_i,
  input  logic            carry_i,
  input  logic            hid_i,
  output logic [XW-1:0]   exp_o,
  output logic            ovf_o,
  output logic            tiny_o
);
  localparam logic [XW-1:0] EMAX = XW'((1 << EXP_W) - 1);

  logic [XW-1:0] e_pre;
  logic [XW-1:0] e_sum;

  // pre-decrement off the rounding path, then add 1 or 2 (bit 1 set on carry)
  assign e_pre  = {1'b0, exp_i} - XW'(1);
  assign e_sum  = e_pre + {{(XW-2){1'b0}}, carry_i, ~carry_i};
  assign tiny_o = (exp_i == '0);
  assign exp_o  = (tiny_o && hid_i) ? XW'(1) : e_sum;
  assign ovf_o  = (exp_o >= EMAX);
endmodule

// File: rtl/fp_exc_pack.sv
`timescale 1ns/1ps
module fp_exc_pack
  import fp_rnd_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int TRAP_BIAS = 192,
  localparam int XW       = EXP_W + 2,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  input  logic            sign_i,
  input  logic [FRAC_W:0] sig_i,
  input  logic [XW-1:0]   exp_i,
  input  logic            ovf_i,
  input  logic            tiny_i,
  input  logic            inx_i,
  input  rnd_mode_e       mode_i,
  input  logic            trap_ovf_i,
  input  logic            trap_unf_i,
  input  logic            nan_i,
  input  logic            inf_i,
  input  logic            clash_i,
  output logic [W-1:0]    result_o,
  output logic            ovf_o,
  output logic            unf_o,
  output logic            inexact_o,
  output logic            invalid_o
);
  localparam logic [EXP_W-1:0] E_ONES = '1;
  localparam logic [EXP_W-1:0] E_MAXF = E_ONES - EXP_W'(1);
  localparam logic [EXP_W-1:0] E_TB   = EXP_W'(TRAP_BIAS);

  logic to_inf;

  always_comb begin
    to_inf    = (mode_i == RM_NEAR_EVEN) || (mode_i == RM_UP && !sign_i) ||
                (mode_i == RM_DOWN && sign_i);
    result_o  = {sign_i, exp_i[EXP_W-1:0], sig_i[FRAC_W-1:0]};
    ovf_o     = 1'b0;
    unf_o     = 1'b0;
    inexact_o = inx_i;
    invalid_o = 1'b0;
    if (nan_i || clash_i) begin
      result_o  = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
      inexact_o = 1'b0;
      invalid_o = 1'b1;
    end else if (inf_i) begin
      result_o  = {sign_i, E_ONES, {FRAC_W{1'b0}}};
      inexact_o = 1'b0;
      invalid_o = 1'b1;
    end else if (ovf_i) begin
      ovf_o = 1'b1;
      if (trap_ovf_i) begin
        result_o[FRAC_W +: EXP_W] = exp_i[EXP_W-1:0] - E_TB;
      end else begin
        inexact_o = 1'b1;
        result_o  = to_inf ? {sign_i, E_ONES, {FRAC_W{1'b0}}}
                           : {sign_i, E_MAXF, {FRAC_W{1'b1}}};
      end
    end else if (tiny_i) begin
      unf_o = inx_i | trap_unf_i;
      if (trap_unf_i) result_o[FRAC_W +: EXP_W] = exp_i[EXP_W-1:0] + E_TB;
    end
  end
endmodule

// File: rtl/fp_round_exc.sv
`timescale 1ns/1ps
module fp_round_exc
  import fp_rnd_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int TRAP_BIAS = 192,
  parameter bit REG_OUT   = 1'b1,
  localparam int SIG_W    = FRAC_W + 1,
  localparam int XW       = EXP_W + 2,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  input  logic [EXP_W:0]    exp_i,
  input  logic              sign_i,
  input  logic              nan_i,
  input  logic              inf_i,
  input  logic              inf_clash_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [W-1:0]      result_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              inexact_o,
  output logic              invalid_o
);
  rnd_mode_e        mode;
  logic [SIG_W-1:0] sig_r;
  logic             carry, inx, ovf, tiny;
  logic [XW-1:0]    exp_r;
  logic [W-1:0]     res_c;
  logic             ovf_c, unf_c, inx_c, inv_c;

  assign mode = rnd_mode_e'(ctrl_i[1:0]);

  fp_round_inc #(.SIG_W(SIG_W)) u_inc (
    .sig_i(sig_i), .guard_i(guard_i), .sticky_i(sticky_i), .sign_i(sign_i),
    .mode_i(mode), .sig_o(sig_r), .carry_o(carry), .inexact_o(inx)
  );

  fp_exp_adj #(.EXP_W(EXP_W)) u_exp (
    .exp_i(exp_i), .carry_i(carry), .hid_i(sig_r[SIG_W-1]),
    .exp_o(exp_r), .ovf_o(ovf), .tiny_o(tiny)
  );

  fp_exc_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .TRAP_BIAS(TRAP_BIAS)) u_pack (
    .sign_i(sign_i), .sig_i(sig_r), .exp_i(exp_r), .ovf_i(ovf), .tiny_i(tiny),
    .inx_i(inx), .mode_i(mode), .trap_ovf_i(ctrl_i[CB_OVF_TRAP]),
    .trap_unf_i(ctrl_i[CB_UNF_TRAP]), .nan_i(nan_i), .inf_i(inf_i),
    .clash_i(inf_clash_i), .result_o(res_c), .ovf_o(ovf_c), .unf_o(unf_c),
    .inexact_o(inx_c), .invalid_o(inv_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o  <= '0;
          ovf_o     <= 1'b0;
          unf_o     <= 1'b0;
          inexact_o <= 1'b0;
          invalid_o <= 1'b0;
        end else begin
          result_o  <= res_c;
          ovf_o     <= ovf_c;
          unf_o     <= unf_c;
          inexact_o <= inx_c;
          invalid_o <= inv_c;
        end
      end

      p_inv_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        invalid_o |-> (!ovf_o && !unf_o && !inexact_o));
      p_ovf_inexact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !$past(ctrl_i[CB_OVF_TRAP])) |-> inexact_o);
      p_rz_no_inf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !$past(ctrl_i[CB_OVF_TRAP]) && $past(ctrl_i[1:0]) == 2'b01)
        |-> (result_o[W-2:0] == {E_MAXF_T, {FRAC_W{1'b1}}}));
      p_trap_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && $past(ctrl_i[CB_OVF_TRAP])) |-> (inexact_o == $past(guard_i | sticky_i)));
      p_unf_tiny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_o |-> ($past(exp_i) == '0));
    end else begin : g_comb
      assign result_o  = res_c;
      assign ovf_o     = ovf_c;
      assign unf_o     = unf_c;
      assign inexact_o = inx_c;
      assign invalid_o = inv_c;
    end
  endgenerate

  localparam logic [EXP_W-1:0] E_MAXF_T = {{(EXP_W-1){1'b1}}, 1'b0};
endmodule

// File: tb/fp_round_exc_test.sv
`timescale 1ns/1ps
module fp_round_exc_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] sig_i = '0;
  logic        guard_i = 1'b0, sticky_i = 1'b0;
  logic [8:0]  exp_i = '0;
  logic        sign_i = 1'b0, nan_i = 1'b0, inf_i = 1'b0, inf_clash_i = 1'b0;
  logic [4:0]  ctrl_i = '0;
  logic [31:0] result_o;
  logic        ovf_o, unf_o, inexact_o, invalid_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  fp_round_exc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i), .guard_i(guard_i),
    .sticky_i(sticky_i), .exp_i(exp_i), .sign_i(sign_i), .nan_i(nan_i),
    .inf_i(inf_i), .inf_clash_i(inf_clash_i), .ctrl_i(ctrl_i),
    .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .inexact_o(inexact_o), .invalid_o(invalid_o)
  );

  function automatic logic [35:0] obs();
    return {result_o, ovf_o, unf_o, inexact_o, invalid_o};
  endfunction

  // expected {result, ovf, unf, inexact, invalid} from the requirements
  function automatic logic [35:0] model(logic [23:0] sg, logic g, logic s, logic [8:0] e,
                                        logic sn, logic nan, logic inf, logic clash,
                                        logic [4:0] c);
    logic up, inx, ovf, unf, ix;
    logic [24:0] sum;
    logic [22:0] fr;
    int ex;
    logic [31:0] r;
    inx = g | s;
    case (c[1:0])
      2'b00: up = g & (s | sg[0]);
      2'b01: up = 1'b0;
      2'b10: up = inx & ~sn;
      default: up = inx & sn;
    endcase
    sum = {1'b0, sg} + 25'(up);
    if (sum[24]) begin fr = '0; ex = int'(e) + 1; end
    else begin fr = sum[22:0]; ex = (e == 0 && sum[23]) ? 1 : int'(e); end
    ovf = 0; unf = 0; ix = inx;
    r = {sn, 8'(ex), fr};
    if (nan | clash) return {32'h7FC00000, 4'b0001};
    if (inf) return {sn, 8'hFF, 23'h0, 4'b0001};
    if (ex >= 255) begin
      ovf = 1;
      if (c[2]) r = {sn, 8'(ex - 192), fr};
      else begin
        ix = 1;
        if (c[1:0] == 2'b00 || (c[1:0] == 2'b10 && !sn) || (c[1:0] == 2'b11 && sn))
          r = {sn, 8'hFF, 23'h0};
        else r = {sn, 8'hFE, 23'h7FFFFF};
      end
    end else if (e == 0) begin
      unf = inx | c[3];
      if (c[3]) r = {sn, 8'(ex + 192), fr};
    end
    return {r, ovf, unf, ix, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
               tag, act[35:4], act[3:0], expv[35:4], expv[3:0]);
    end
  endtask

  task automatic run(input string tag, input logic [23:0] sg, input logic g, input logic s,
                     input logic [8:0] e, input logic sn, input logic nan, input logic inf,
                     input logic clash, input logic [4:0] c, input logic [35:0] expv);
    @(negedge clk_i);
    sig_i = sg; guard_i = g; sticky_i = s; exp_i = e; sign_i = sn;
    nan_i = nan; inf_i = inf; inf_clash_i = clash; ctrl_i = c;
    @(negedge clk_i);
    check(tag, obs(), expv);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [35:0] prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R11 reset", obs(), 36'h0);
    rst_ni = 1'b1;

    // R1 ties
    run("R1 tie even", 24'h800000, 1, 0, 9'd127, 0, 0, 0, 0, 5'b00000, {32'h3F800000, 4'b0010});
    run("R1 tie odd",  24'h800001, 1, 0, 9'd127, 0, 0, 0, 0, 5'b00000, {32'h3F800002, 4'b0010});
    run("R1 below half", 24'h800001, 0, 1, 9'd127, 0, 0, 0, 0, 5'b00000, {32'h3F800001, 4'b0010});
    // R2 directed modes
    run("R2 trunc", 24'h800001, 1, 1, 9'd127, 0, 0, 0, 0, 5'b00001, {32'h3F800001, 4'b0010});
    run("R2 up pos", 24'h800000, 0, 1, 9'd127, 0, 0, 0, 0, 5'b00010, {32'h3F800001, 4'b0010});
    run("R2 up neg", 24'h800000, 0, 1, 9'd127, 1, 0, 0, 0, 5'b00010, {32'hBF800000, 4'b0010});
    run("R2 down neg", 24'h800000, 0, 1, 9'd127, 1, 0, 0, 0, 5'b00011, {32'hBF800001, 4'b0010});
    // R3 carry out
    run("R3 carry", 24'hFFFFFF, 1, 1, 9'd127, 0, 0, 0, 0, 5'b00000, {32'h40000000, 4'b0010});
    // R4 subnormal promotion
    run("R4 promote", 24'h7FFFFF, 1, 0, 9'd0, 0, 0, 0, 0, 5'b00000, {32'h00800000, 4'b0110});
    // R5 untrapped overflow
    run("R5 ovf inf", 24'hFFFFFF, 1, 0, 9'd254, 0, 0, 0, 0, 5'b00000, {32'h7F800000, 4'b1010});
    run("R5 ovf trunc", 24'hFFFFFF, 1, 0, 9'd255, 0, 0, 0, 0, 5'b00001, {32'h7F7FFFFF, 4'b1010});
    run("R5 ovf down pos", 24'h800000, 0, 0, 9'd260, 0, 0, 0, 0, 5'b00011, {32'h7F7FFFFF, 4'b1010});
    // R6 trapped overflow
    run("R6 trap ovf", 24'hFFFFFF, 0, 0, 9'd255, 0, 0, 0, 0, 5'b00100, {32'h1FFFFFFF, 4'b1000});
    // R7 underflow
    run("R7 unf inexact", 24'h000100, 0, 1, 9'd0, 0, 0, 0, 0, 5'b00001, {32'h00000100, 4'b0110});
    run("R7 tiny exact", 24'h000100, 0, 0, 9'd0, 0, 0, 0, 0, 5'b00000, {32'h00000100, 4'b0000});
    run("R7 trap unf", 24'h000100, 0, 0, 9'd0, 0, 0, 0, 0, 5'b01000, {32'h60000100, 4'b0100});
    // R8 specials
    run("R8 nan", 24'h800000, 1, 1, 9'd100, 1, 1, 0, 0, 5'b00000, {32'h7FC00000, 4'b0001});
    run("R8 clash", 24'h800000, 0, 0, 9'd100, 0, 0, 1, 1, 5'b00000, {32'h7FC00000, 4'b0001});
    run("R8 inf", 24'h800000, 1, 0, 9'd255, 1, 0, 1, 0, 5'b00000, {32'hFF800000, 4'b0001});
    // R9 exact ordinary
    run("R9 exact", 24'hC00000, 0, 0, 9'd130, 1, 0, 0, 0, 5'b00000, {32'hC1400000, 4'b0000});
    // R10 operation bit ignored
    run("R10 op bit", 24'h800001, 1, 0, 9'd127, 0, 0, 0, 0, 5'b10000, {32'h3F800002, 4'b0010});
    run("R10 op bit ovf", 24'hFFFFFF, 1, 0, 9'd254, 0, 0, 0, 0, 5'b10000, {32'h7F800000, 4'b1010});

    // R11 latency: output holds until the next edge
    @(negedge clk_i);
    prev = obs();
    sig_i = 24'h900000; guard_i = 0; sticky_i = 0; exp_i = 9'd127; sign_i = 0;
    nan_i = 0; inf_i = 0; inf_clash_i = 0; ctrl_i = 5'b00000;
    #1 check("R11 hold", obs(), prev);
    @(negedge clk_i);
    check("R11 update", obs(), {32'h3F900000, 4'b0000});

    for (int i = 0; i < 3000; i++) begin
      logic [23:0] sg;
      logic [8:0] e;
      logic g, s, sn, nan, inf, clash;
      logic [4:0] c;
      case ($urandom % 8)
        0: e = 9'd0;
        1: e = 9'd1;
        2: e = 9'(253 + $urandom % 4);
        3: e = 9'(255 + $urandom % 8);
        default: e = 9'(1 + $urandom % 254);
      endcase
      sg = 24'($urandom);
      sg[23] = (e != 0);
      if ($urandom % 4 == 0) sg[22:0] = '1;
      g = 1'($urandom); s = 1'($urandom); sn = 1'($urandom);
      nan = ($urandom % 16) == 0;
      inf = ($urandom % 16) == 0;
      clash = inf & 1'($urandom);
      c = 5'($urandom);
      run("R1 R2 R5 R6 R7 R9 R10 random", sg, g, s, e, sn, nan, inf, clash, c,
          model(sg, g, s, e, sn, nan, inf, clash, c));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule